// File: doc/BRIEF.md
# Strict-Priority Weighted Packet Scheduler

This block picks which of four packet queues transmits the next packet. Every queue carries a programmable priority level and a programmable weight. Any non-empty queue at a higher level always wins over queues at lower levels. Queues that share the highest occupied level take turns in round-robin order, and each takes one packet per turn. Over one round, a queue with weight N is granted exactly N packets.

The surrounding logic reports which queues hold data and raises a one-cycle request when it is ready for a new decision. The scheduler answers with a registered one-hot grant and a valid flag. It holds that grant until the surrounding logic signals that the packet has fully left. Each queue has a credit counter. The counter is loaded with the queue's weight when a round starts and is charged one unit when a granted packet completes. When no non-empty queue at the active level has credit left, the credits of every queue at that level are loaded again.

Top module: `prio_wrr_sched`

## Requirements
- R1: After reset, `grantValid` is 0, `grant` is all zeros, every credit is empty, and the round-robin pointer sits at queue 3, so queue 0 is searched first.
- R2: A request made while `qNonEmpty` is all zeros produces no grant, and it is not remembered for later.
- R3: A request made while idle with at least one non-empty queue causes `grantValid` to rise on the next clock edge. The grant is then one-hot, bit i stands for queue i, and it points at a queue that was non-empty when the request was sampled.
- R4: Priority levels are unsigned `PRIO_W`-bit fields, and a larger value means higher priority. The granted queue's level is never below the level of any queue that was non-empty at the decision.
- R5: While `grantValid` is 1, `grant` stays unchanged until `pktDone` is sampled. `grantValid` falls on that same clock edge.
- R6: `nextReq` is ignored while a grant is outstanding. This includes a request in the same cycle as `pktDone`; no new grant follows from it.
- R7: Among the non-empty queues at the active level, queues with credit left are served one packet per turn. The search starts at the queue after the one granted last. With all of them continuously non-empty, a queue with weight N receives N grants per round.
- R8: A weight field of 0 is treated as a weight of 1.
- R9: When every non-empty queue at the active level has zero credit, a request loads the credits of every queue at that level with their weights. A grant is still issued in the same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| qNonEmpty | input | NUM_Q | Bit i is set when queue i holds at least one packet |
| qPrio | input | NUM_Q*PRIO_W | Priority level of each queue, queue i in bits [i*PRIO_W +: PRIO_W] |
| qWeight | input | NUM_Q*WEIGHT_W | Weight of each queue, queue i in bits [i*WEIGHT_W +: WEIGHT_W] |
| nextReq | input | 1 | Asks for a scheduling decision; acted on only while idle |
| pktDone | input | 1 | The granted packet has finished; acted on only while a grant is outstanding |
| grant | output | NUM_Q | One-hot granted queue, zero when no grant is outstanding |
| grantValid | output | 1 | A grant is outstanding |

## Verification
Two events can fall in the same cycle: the end of a packet (`pktDone`) and a fresh request (`nextReq`). The request must lose, because the block is still busy at that edge. The bench raises both in one cycle and checks that `grantValid` falls and stays low on the following cycle, with no new grant. A credit reload and the choice of the first queue of the new round also happen in the same decision. The bench forces this with zero and small weights and compares each grant against a credit model computed arithmetically in the bench.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic decide;  // take a scheduling decision this cycle
    logic retire;  // the outstanding packet finished this cycle
  } schedStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } schedState_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         nextReq,
  input  logic         pktDone,
  input  logic         anyWork,
  output schedStrobe_t strobe,
  output logic         busy
);
  schedState_t state;

  always_comb begin
    strobe.decide = (state == ST_IDLE) && nextReq && anyWork;
    strobe.retire = (state == ST_BUSY) && pktDone;
  end

  assign busy = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.decide) state <= ST_BUSY;
        ST_BUSY: if (strobe.retire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a request during an outstanding grant does not end the busy phase
  a_r6_req_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && nextReq && !pktDone) |=> busy);

  // R2: with nothing queued, an idle request leaves the block idle
  a_r2_idle_no_work: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyWork) |=> !busy);
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import sched_pkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int PRIO_W   = 2,
  parameter int WEIGHT_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  schedStrobe_t              strobe,
  input  logic [NUM_Q-1:0]          qNonEmpty,
  input  logic [NUM_Q*PRIO_W-1:0]   qPrio,
  input  logic [NUM_Q*WEIGHT_W-1:0] qWeight,
  output logic                      anyWork,
  output logic [NUM_Q-1:0]          grant,
  output logic                      grantValid
);
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [PRIO_W-1:0]   prioArr   [NUM_Q];
  logic [WEIGHT_W-1:0] effWeight [NUM_Q];
  logic [WEIGHT_W-1:0] credit    [NUM_Q];

  logic [PRIO_W-1:0] activeLvl;
  logic [NUM_Q-1:0]  cand, elig, pool;
  logic              needReload;
  logic [IDX_W-1:0]  lastIdx, pickIdx, grantIdx;
  logic              anyHigher;

  // Unpack per-queue fields; a zero weight behaves as one.
  for (genvar g = 0; g < NUM_Q; g++) begin : g_unpack
    assign prioArr[g]   = qPrio[g*PRIO_W +: PRIO_W];
    assign effWeight[g] = (qWeight[g*WEIGHT_W +: WEIGHT_W] == '0)
                          ? WEIGHT_W'(1) : qWeight[g*WEIGHT_W +: WEIGHT_W];
    assign cand[g] = qNonEmpty[g] && (prioArr[g] == activeLvl);
    assign elig[g] = cand[g] && (credit[g] != '0);
  end

  assign anyWork    = |qNonEmpty;
  assign needReload = (|cand) && !(|elig);
  assign pool       = needReload ? cand : elig;

  // Highest level holding data.
  always_comb begin
    activeLvl = '0;
    for (int i = 0; i < NUM_Q; i++)
      if (qNonEmpty[i] && (prioArr[i] > activeLvl)) activeLvl = prioArr[i];
  end

  // Round-robin search starting after the last granted queue.
  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = lastIdx;
    for (int k = 1; k <= NUM_Q; k++) begin
      int j;
      j = (int'(lastIdx) + k) % NUM_Q;
      if (!found && pool[j]) begin
        pickIdx = IDX_W'(j);
        found   = 1'b1;
      end
    end
  end

  // Independent scan: is any non-empty queue above the picked one?
  always_comb begin
    anyHigher = 1'b0;
    for (int i = 0; i < NUM_Q; i++)
      if (qNonEmpty[i] && (prioArr[i] > prioArr[pickIdx])) anyHigher = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_Q; i++) credit[i] <= '0;
      lastIdx    <= IDX_W'(NUM_Q - 1);
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else begin
      if (strobe.decide) begin
        grantIdx   <= pickIdx;
        grantValid <= 1'b1;
        if (needReload)
          for (int i = 0; i < NUM_Q; i++)
            if (prioArr[i] == activeLvl) credit[i] <= effWeight[i];
      end
      if (strobe.retire) begin
        grantValid       <= 1'b0;
        lastIdx          <= grantIdx;
        credit[grantIdx] <= credit[grantIdx] - WEIGHT_W'(1);
      end
    end
  end

  assign grant = grantValid ? (NUM_Q'(1) << grantIdx) : '0;

  // R4: the decision never passes over a higher-level non-empty queue
  a_r4_no_higher_waiting: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |-> !anyHigher);

  // R3: a decision yields a grant to a queue that held data
  a_r3_grant_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |=> (grantValid && ((grant & $past(qNonEmpty)) != '0)));

  // R7: a completed packet always has a credit to charge
  a_r7_credit_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |-> (credit[grantIdx] != '0));

  // R9: a reload leaves the picked queue with credit
  a_r9_reload_gives_credit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decide && needReload) |=> (credit[grantIdx] != '0));
endmodule

// File: rtl/prio_wrr_sched.sv
module prio_wrr_sched
  import sched_pkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int PRIO_W   = 2,
  parameter int WEIGHT_W = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_Q-1:0]          qNonEmpty,
  input  logic [NUM_Q*PRIO_W-1:0]   qPrio,
  input  logic [NUM_Q*WEIGHT_W-1:0] qWeight,
  input  logic                      nextReq,
  input  logic                      pktDone,
  output logic [NUM_Q-1:0]          grant,
  output logic                      grantValid
);
  schedStrobe_t strobe;
  logic         anyWork;
  logic         busy;

  sched_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .nextReq (nextReq),
    .pktDone (pktDone),
    .anyWork (anyWork),
    .strobe  (strobe),
    .busy    (busy)
  );

  sched_dp #(
    .NUM_Q    (NUM_Q),
    .PRIO_W   (PRIO_W),
    .WEIGHT_W (WEIGHT_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .qNonEmpty  (qNonEmpty),
    .qPrio      (qPrio),
    .qWeight    (qWeight),
    .anyWork    (anyWork),
    .grant      (grant),
    .grantValid (grantValid)
  );

  // R5: grant is held unchanged until the packet finishes
  a_r5_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !pktDone) |=> (grantValid && $stable(grant)));

  // R5: completion clears the grant on that edge
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && pktDone) |=> !grantValid);

  // R3: the grant flag and the one-hot vector agree
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == ($countones(grant) == 1));

  // R6 / R5: the busy phase matches the grant flag
  a_r6_busy_matches: assert property (@(posedge clk) disable iff (!rstN)
    busy == grantValid);
endmodule

// File: tb/test_prio_wrr_sched.sv
module test_prio_wrr_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] ne = '0;
  logic [7:0] prioFlat = '0;
  logic [19:0] weightFlat = '0;
  logic       nextReq = 1'b0;
  logic       pktDone = 1'b0;
  logic [3:0] grant;
  logic       grantValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mCredit [NQ];
  int mLast;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_wrr_sched i_prio_wrr_sched (
    .clk(clk), .rstN(rstN), .qNonEmpty(ne), .qPrio(prioFlat), .qWeight(weightFlat),
    .nextReq(nextReq), .pktDone(pktDone), .grant(grant), .grantValid(grantValid)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int pr(int q);
    return int'(prioFlat[q*2 +: 2]);
  endfunction

  function automatic int wt(int q);
    int w;
    w = int'(weightFlat[q*5 +: 5]);
    return (w == 0) ? 1 : w;
  endfunction

  // Model of a decision from the requirements; returns -1 if none.
  task automatic modelDecide(output int pick);
    int lvl, eligCnt, candCnt;
    bit useCand;
    lvl = 0; eligCnt = 0; candCnt = 0;
    for (int i = 0; i < NQ; i++) if (ne[i] && pr(i) > lvl) lvl = pr(i);
    for (int i = 0; i < NQ; i++)
      if (ne[i] && pr(i) == lvl) begin
        candCnt++;
        if (mCredit[i] > 0) eligCnt++;
      end
    pick = -1;
    if (candCnt == 0) return;
    useCand = (eligCnt == 0);
    if (useCand)
      for (int i = 0; i < NQ; i++) if (pr(i) == lvl) mCredit[i] = wt(i);
    for (int k = 1; k <= NQ; k++) begin
      int j;
      j = (mLast + k) % NQ;
      if (pick < 0 && ne[j] && pr(j) == lvl && mCredit[j] > 0) pick = j;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; nextReq = 1'b0; pktDone = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NQ; i++) mCredit[i] = 0;
    mLast = NQ - 1;
  endtask

  // One request plus completion; checks grant against the model.
  task automatic serve(string tag, output int got);
    int exp;
    modelDecide(exp);
    nextReq = 1'b1;
    @(negedge clk);
    nextReq = 1'b0;
    got = -1;
    for (int i = 0; i < NQ; i++) if (grant[i]) got = i;
    if (exp < 0) begin
      check({tag, " R2 no grant"}, int'(grantValid), 0);
    end else begin
      check({tag, " R3 valid"}, int'(grantValid), 1);
      check({tag, " R4/R7 grant"}, int'(grant), 1 << exp);
      @(negedge clk);
      check({tag, " R5 held"}, int'(grant), 1 << exp);
      pktDone = 1'b1;
      @(negedge clk);
      pktDone = 1'b0;
      check({tag, " R5 cleared"}, int'(grantValid), 0);
      mCredit[exp]--;
      mLast = exp;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got, cnt2, cnt3;
    int seq [4];
    doReset();
    // R1: reset state
    check("R1 grantValid", int'(grantValid), 0);
    check("R1 grant", int'(grant), 0);

    // R2: request with nothing queued, then data appears without a request
    ne = 4'b0000;
    serve("r2_empty", got);
    ne = 4'b0110;
    @(negedge clk);
    check("R2 not remembered", int'(grantValid), 0);

    // R8: weight 0 acts as 1; q0 w0, q1 w2, both level 1
    doReset();
    prioFlat = {2'd0, 2'd0, 2'd1, 2'd1};
    weightFlat = {5'd4, 5'd4, 5'd2, 5'd0};
    ne = 4'b0011;
    for (int n = 0; n < 4; n++) serve("r8_zero_w", seq[n]);
    check("R8 seq0", seq[0], 0);
    check("R8 seq1", seq[1], 1);
    check("R8 seq2", seq[2], 1);
    check("R8 seq3 R9 reload", seq[3], 0);

    // R7: weights 3 and 1 at level 2; 8 grants split 6:2
    doReset();
    prioFlat = {2'd2, 2'd2, 2'd0, 2'd0};
    weightFlat = {5'd1, 5'd3, 5'd9, 5'd9};
    ne = 4'b1111;
    cnt2 = 0; cnt3 = 0;
    for (int n = 0; n < 8; n++) begin
      serve("r7_ratio", got);
      if (got == 2) cnt2++;
      if (got == 3) cnt3++;
    end
    check("R7 q2 count", cnt2, 6);
    check("R7 q3 count", cnt3, 2);

    // R6: request alongside pktDone is dropped; request while busy is ignored
    serve("r6_pre", got);
    nextReq = 1'b1;
    @(negedge clk);
    nextReq = 1'b1;
    @(negedge clk);
    check("R6 busy req no change", int'(grantValid), 1);
    nextReq = 1'b1; pktDone = 1'b1;
    @(negedge clk);
    nextReq = 1'b0; pktDone = 1'b0;
    check("R6 done edge clears", int'(grantValid), 0);
    @(negedge clk);
    check("R6 same-cycle req dropped", int'(grantValid), 0);
    begin
      int e;
      modelDecide(e);
      mCredit[e]--; mLast = e;
    end

    // R4/R7/R9 sweep over configurations and occupancy patterns
    for (int cfg = 0; cfg < 12; cfg++) begin
      for (int q = 0; q < NQ; q++) begin
        prioFlat[q*2 +: 2]   = 2'((cfg * (q + 1) + q) % 4);
        weightFlat[q*5 +: 5] = 5'((cfg * 7 + q * 5) % 6);
      end
      for (int step = 0; step < 40; step++) begin
        ne = 4'((step * 5 + cfg * 3 + (step / 4)) % 16);
        serve("sweep", got);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule